// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block gathers 128 level-sensitive interrupt lines, organised as four banks of 32, into a single interrupt request to a processor. Software reaches it through a 32-bit register port with a combinational read path. Each source has a mask bit and a software-forced bit. A source is pending while its input line or its forced bit is high and its mask bit is clear. Mask bits and forced bits are changed only by write-one-to-set and write-one-to-clear addresses in each bank.

When no source is held and pending sources exist, the lowest-numbered one is captured. The controller raises its request and keeps the captured number frozen until software writes the end-of-service bit. A read of the sorted-source register returns that number. The upper bits of that read flag the result as spurious when nothing is held, or when the held source has since been masked or has dropped.

A soft reset, started from the configuration register, restores every piece of state over a fixed number of cycles and reports completion in a status bit. A threshold register can stop new captures. A read-only revision register identifies the block.

Top module: `icVecCtl`

## Requirements
- R1: After the reset input, every mask bit is 1, every forced bit is 0, irqOut is low, the threshold reads 0xFF, status bit 0 reads 1, and the sorted read at 0x40 returns all ones in bits [31:7].
- R2: For bank b, a write to 0x88+b*0x20 clears the mask bits where the write data is 1, and a write to 0x8C+b*0x20 sets them. Zero data bits leave mask bits unchanged. Reading either address returns the bank's mask, and source n maps to bank n>>5, bit n&31.
- R3: A write to 0x90+b*0x20 sets forced bits and a write to 0x94+b*0x20 clears them, one bit per source. Reading 0x90+b*0x20 returns the forced bits, and reading 0x94+b*0x20 returns input OR forced for that bank. A forced bit makes its source pending exactly like a high input.
- R4: With nothing held, the lowest-numbered unmasked pending source is captured on the next clock edge, and irqOut is high from that edge on.
- R5: While a source is held, its number and irqOut stay unchanged, even if a lower-numbered source becomes pending or the held source stops pending, until an end-of-service write or a soft reset.
- R6: A write to 0x48 with bit 0 set releases the held source, and irqOut is low after that edge. If a source is still pending, a new capture happens on the following edge. A write to 0x48 with bit 0 clear has no effect.
- R7: A read of 0x40 returns the held number in bits [6:0]. Bits [31:7] are all ones when nothing is held, or when the held source is masked or no longer pending, and all zeros otherwise.
- R8: A write to 0x10 with bit 1 set starts a soft reset. Status bit 0 at 0x14 reads 0 for RST_CYCLES cycles and then 1. The reset restores the R1 state, and bus writes made while it is busy are ignored.
- R9: The threshold register at 0x68 holds 8 bits. Every source has fixed priority 0, so a threshold of 0 blocks new captures and any nonzero value allows them.
- R10: Offset 0x00 reads the major revision in bits [7:4] and the minor revision in bits [3:0] (default 0x50). Writes to it have no effect.
- R11: Detection is by level only. A source whose input rises and falls while another source is held is not remembered after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |
| srcLevel | input | NUM_SRC | Level-sensitive interrupt input lines |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is a sorted read that returns a held number with the spurious flag set. Getting there needs a source captured and then withdrawn while irqOut stays high. The bench captures a source through its forced bit, clears that bit before the end-of-service write, and reads 0x40 in between. It also reaches the case where a source pulses while another is held and has gone before release. Random rounds of mask, forced-bit and input patterns then exercise lowest-number selection after each release.

// File: rtl/icPkg.sv
package icPkg;

  // Strobes from the register control into the datapath
  typedef struct packed {
    logic clrAll;
    logic maskSet;
    logic maskClr;
    logic swSet;
    logic swClr;
    logic eoi;
    logic thrWr;
  } icStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_REV,
    RD_STATUS,
    RD_SORTED,
    RD_THR,
    RD_MASK,
    RD_SW,
    RD_RAW
  } icRdSel_t;

  localparam logic [7:0] OFS_REV      = 8'h00;
  localparam logic [7:0] OFS_SYSCFG   = 8'h10;
  localparam logic [7:0] OFS_STATUS   = 8'h14;
  localparam logic [7:0] OFS_SORTED   = 8'h40;
  localparam logic [7:0] OFS_CTRL     = 8'h48;
  localparam logic [7:0] OFS_THR      = 8'h68;
  localparam logic [7:0] OFS_BANK0    = 8'h88;
  localparam int         BANK_STRIDE_LOG2 = 5;

endpackage

// File: rtl/icRegCtl.sv
module icRegCtl
  import icPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_BANK   = 4,
  parameter int RST_CYCLES = 4,
  localparam int BANK_IDX_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int CNT_W      = $clog2(RST_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output icStrobe_t             strb,
  output icRdSel_t              rdSel,
  output logic [BANK_IDX_W-1:0] bankSel,
  output logic                  busy
);

  logic [CNT_W-1:0]  rstCnt;
  logic [ADDR_W-1:0] bankOff;
  logic [2:0]        slot;
  logic              inBankWin;
  logic              wrAccept;
  logic              startRst;

  assign bankOff   = busAddr - ADDR_W'(OFS_BANK0);
  assign slot      = bankOff[4:2];
  assign bankSel   = bankOff[BANK_STRIDE_LOG2 +: BANK_IDX_W];
  assign inBankWin = (busAddr >= ADDR_W'(OFS_BANK0)) &&
                     (32'(bankOff[ADDR_W-1:BANK_STRIDE_LOG2]) < 32'(NUM_BANK)) &&
                     (bankOff[1:0] == 2'b00) && (slot < 3'd4);

  assign busy     = (rstCnt != '0);
  assign wrAccept = busWrEn && !busy;
  assign startRst = wrAccept && (busAddr == ADDR_W'(OFS_SYSCFG)) && busWrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rstCnt <= '0;
    else if (startRst) rstCnt <= CNT_W'(RST_CYCLES);
    else if (busy)     rstCnt <= rstCnt - 1'b1;
  end

  always_comb begin
    strb         = '0;
    strb.clrAll  = busy;
    strb.eoi     = wrAccept && (busAddr == ADDR_W'(OFS_CTRL)) && busWrData[0];
    strb.thrWr   = wrAccept && (busAddr == ADDR_W'(OFS_THR));
    strb.maskClr = wrAccept && inBankWin && (slot == 3'd0);
    strb.maskSet = wrAccept && inBankWin && (slot == 3'd1);
    strb.swSet   = wrAccept && inBankWin && (slot == 3'd2);
    strb.swClr   = wrAccept && inBankWin && (slot == 3'd3);
  end

  always_comb begin
    rdSel = RD_NONE;
    if (busAddr == ADDR_W'(OFS_REV))         rdSel = RD_REV;
    else if (busAddr == ADDR_W'(OFS_STATUS)) rdSel = RD_STATUS;
    else if (busAddr == ADDR_W'(OFS_SORTED)) rdSel = RD_SORTED;
    else if (busAddr == ADDR_W'(OFS_THR))    rdSel = RD_THR;
    else if (inBankWin) begin
      case (slot)
        3'd0, 3'd1: rdSel = RD_MASK;
        3'd2:       rdSel = RD_SW;
        default:    rdSel = RD_RAW;
      endcase
    end
  end

endmodule

// File: rtl/icPrioEnc.sv
module icPrioEnc #(
  parameter int N    = 128,
  parameter int ID_W = 7
) (
  input  logic [N-1:0]    req,
  output logic            found,
  output logic [ID_W-1:0] id
);

  // Lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    id    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        id    = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/icDatapath.sv
module icDatapath
  import icPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANK  = 4,
  parameter int REV_MAJOR = 5,
  parameter int REV_MINOR = 0,
  localparam int NUM_SRC    = NUM_BANK * DATA_W,
  localparam int ID_W       = $clog2(NUM_SRC),
  localparam int BANK_IDX_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  icStrobe_t             strb,
  input  icRdSel_t              rdSel,
  input  logic [BANK_IDX_W-1:0] bankSel,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic [NUM_SRC-1:0]    srcLevel,
  output logic [DATA_W-1:0]     busRdData,
  output logic                  holdValid,
  output logic [ID_W-1:0]       holdId
);

  localparam logic [3:0] REV_MAJ = 4'(REV_MAJOR);
  localparam logic [3:0] REV_MIN = 4'(REV_MINOR);

  logic [NUM_SRC-1:0] maskAll;
  logic [NUM_SRC-1:0] swAll;
  logic [NUM_SRC-1:0] rawAll;
  logic [NUM_SRC-1:0] pending;
  logic [7:0]         thrQ;
  logic               found;
  logic [ID_W-1:0]    foundId;
  logic               heldLive;

  for (genvar b = 0; b < NUM_BANK; b++) begin : gBank
    logic [DATA_W-1:0] maskQ;
    logic [DATA_W-1:0] swQ;
    logic              hit;

    assign hit = (bankSel == BANK_IDX_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ <= '1;
        swQ   <= '0;
      end else if (strb.clrAll) begin
        maskQ <= '1;
        swQ   <= '0;
      end else if (hit) begin
        if (strb.maskSet)      maskQ <= maskQ | busWrData;
        else if (strb.maskClr) maskQ <= maskQ & ~busWrData;
        if (strb.swSet)        swQ   <= swQ | busWrData;
        else if (strb.swClr)   swQ   <= swQ & ~busWrData;
      end
    end

    assign maskAll[b*DATA_W +: DATA_W] = maskQ;
    assign swAll[b*DATA_W +: DATA_W]   = swQ;
  end

  assign rawAll  = srcLevel | swAll;
  assign pending = rawAll & ~maskAll;

  icPrioEnc #(.N(NUM_SRC), .ID_W(ID_W)) i_prioEnc (
    .req  (pending),
    .found(found),
    .id   (foundId)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             thrQ <= 8'hFF;
    else if (strb.clrAll)  thrQ <= 8'hFF;
    else if (strb.thrWr)   thrQ <= busWrData[7:0];
  end

  // Capture and hold the selected source until end of service
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdId    <= '0;
    end else if (strb.clrAll) begin
      holdValid <= 1'b0;
      holdId    <= '0;
    end else if (strb.eoi) begin
      holdValid <= 1'b0;
    end else if (!holdValid && found && (thrQ != 8'h00)) begin
      holdValid <= 1'b1;
      holdId    <= foundId;
    end
  end

  assign heldLive = pending[holdId];

  always_comb begin
    busRdData = '0;
    case (rdSel)
      RD_REV:    busRdData = DATA_W'({REV_MAJ, REV_MIN});
      RD_STATUS: busRdData = DATA_W'(!strb.clrAll);
      RD_SORTED: busRdData = {{(DATA_W-ID_W){!(holdValid && heldLive)}}, holdId};
      RD_THR:    busRdData = DATA_W'(thrQ);
      RD_MASK:   busRdData = maskAll[int'(bankSel)*DATA_W +: DATA_W];
      RD_SW:     busRdData = swAll[int'(bankSel)*DATA_W +: DATA_W];
      RD_RAW:    busRdData = rawAll[int'(bankSel)*DATA_W +: DATA_W];
      default:   busRdData = '0;
    endcase
  end

endmodule

// File: rtl/icVecCtl.sv
module icVecCtl
  import icPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_BANK   = 4,
  parameter int RST_CYCLES = 4,
  parameter int REV_MAJOR  = 5,
  parameter int REV_MINOR  = 0,
  localparam int NUM_SRC    = NUM_BANK * DATA_W,
  localparam int ID_W       = $clog2(NUM_SRC),
  localparam int BANK_IDX_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic               irqOut
);

  icStrobe_t             strb;
  icRdSel_t              rdSel;
  logic [BANK_IDX_W-1:0] bankSel;
  logic                  busy;
  logic                  holdValid;
  logic [ID_W-1:0]       holdId;

  icRegCtl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANK(NUM_BANK), .RST_CYCLES(RST_CYCLES)
  ) i_regCtl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .strb(strb), .rdSel(rdSel), .bankSel(bankSel), .busy(busy)
  );

  icDatapath #(
    .DATA_W(DATA_W), .NUM_BANK(NUM_BANK), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .bankSel(bankSel),
    .busWrData(busWrData), .srcLevel(srcLevel), .busRdData(busRdData),
    .holdValid(holdValid), .holdId(holdId)
  );

  assign irqOut = holdValid;

endmodule

// File: rtl/icVecCtlChk.sv
module icVecCtlChk
  import icPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              irqOut,
  input logic [ID_W-1:0]   holdId,
  input logic              busy
);

  logic eoiWr;
  assign eoiWr = busWrEn && (busAddr == ADDR_W'(OFS_CTRL)) && busWrData[0];

  AST_EOI_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && !busy && irqOut) |=> !irqOut); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !busy && !eoiWr) |=> (irqOut && $stable(holdId))); // R5

  AST_SOFTRST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !irqOut); // R8

  AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && busAddr == ADDR_W'(OFS_SORTED)) |-> (&busRdData[DATA_W-1:ID_W])); // R7

endmodule

bind icVecCtl icVecCtlChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
  .busRdData(busRdData), .irqOut(irqOut), .holdId(holdId), .busy(busy)
);

// File: tb/test_icVecCtl.sv
module test_icVecCtl;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NBANK   = 4;
  localparam int NSRC    = NBANK * DATA_W;
  localparam int RSTCYC  = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] busAddr;
  logic              busWrEn;
  logic [DATA_W-1:0] busWrData;
  logic [DATA_W-1:0] busRdData;
  logic [NSRC-1:0]   srcLevel;
  logic              irqOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  icVecCtl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANK(NBANK), .RST_CYCLES(RSTCYC)) i_icVecCtl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .srcLevel(srcLevel), .irqOut(irqOut)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lowestPending(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] bankAddr(input int b, input int slot);
    return 8'(8'h88 + b * 8'h20 + slot * 4);
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NSRC-1:0] modelMask, modelSw, modelSrc;
    int exp, cnt;
    int unsigned seedVal;
    rstN = 1'b0; busAddr = '0; busWrEn = 1'b0; busWrData = '0; srcLevel = '0;
    seedVal = $urandom(32'd2024);
    tick(); tick(); tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    for (int b = 0; b < NBANK; b++) begin
      rd(bankAddr(b, 0), d); check("R1 mask", d, 32'hFFFFFFFF);
      rd(bankAddr(b, 2), d); check("R1 sw", d, 32'h0);
    end
    check("R1 irq", 32'(irqOut), 32'h0);
    rd(8'h14, d); check("R1 status", d, 32'h1);
    rd(8'h68, d); check("R1 thr", d, 32'hFF);
    rd(8'h40, d); check("R1 R7 sorted idle", d & 32'hFFFFFF80, 32'hFFFFFF80);

    // R10 revision
    rd(8'h00, d); check("R10 rev", d, 32'h50);
    wr(8'h00, 32'h12);
    rd(8'h00, d); check("R10 rev write ignored", d, 32'h50);

    // R2 mask W1C / W1S
    wr(8'hA8, 32'h0000F00F);
    rd(8'hA8, d); check("R2 mask clr", d, 32'hFFFF0FF0);
    wr(8'hAC, 32'h00000003);
    rd(8'hAC, d); check("R2 mask set", d, 32'hFFFF0FF3);
    wr(8'hAC, 32'h0);
    rd(8'hA8, d); check("R2 zero write", d, 32'hFFFF0FF3);
    rd(8'h88, d); check("R2 other bank", d, 32'hFFFFFFFF);

    // R3 forced bits, source 69 = bank 2 bit 5
    wr(8'hD0, 32'h20);
    tick();
    check("R3 masked forced no irq", 32'(irqOut), 32'h0);
    rd(8'hD0, d); check("R3 sw read", d, 32'h20);
    rd(8'hD4, d); check("R3 raw read", d, 32'h20);
    wr(8'hC8, 32'h20);
    check("R4 irq not before capture edge", 32'(irqOut), 32'h0);
    tick();
    check("R4 irq after capture", 32'(irqOut), 32'h1);
    rd(8'h40, d); check("R4 R7 sorted 69", d, 32'd69);

    // R5 lower source appears, held stays
    srcLevel[34] = 1'b1;
    tick(); tick();
    rd(8'h40, d); check("R5 held stable", d, 32'd69);

    // R7 withdrawn held source reads spurious
    wr(8'hD4, 32'h20);
    rd(8'h40, d); check("R7 withdrawn spurious", d, 32'hFFFFFFC5);
    check("R5 irq stays", 32'(irqOut), 32'h1);

    // R6 end of service
    wr(8'h48, 32'h0);
    check("R6 bit0 clear no effect", 32'(irqOut), 32'h1);
    wr(8'h48, 32'h1);
    check("R6 irq drops", 32'(irqOut), 32'h0);
    tick();
    check("R6 irq reasserts", 32'(irqOut), 32'h1);
    rd(8'h40, d); check("R6 new source 34", d, 32'd34);

    // R11 pulse not remembered
    srcLevel[35] = 1'b1; tick(); srcLevel[35] = 1'b0;
    srcLevel[34] = 1'b0;
    wr(8'h48, 32'h1);
    tick();
    check("R11 pulse forgotten", 32'(irqOut), 32'h0);
    rd(8'h40, d); check("R11 R7 spurious", d & 32'hFFFFFF80, 32'hFFFFFF80);

    // R9 threshold
    wr(8'h68, 32'h0);
    rd(8'h68, d); check("R9 thr read", d, 32'h0);
    srcLevel[44] = 1'b1;
    tick(); tick();
    check("R9 thr 0 blocks", 32'(irqOut), 32'h0);
    wr(8'h68, 32'h80);
    tick();
    check("R9 thr nonzero allows", 32'(irqOut), 32'h1);
    rd(8'h40, d); check("R9 sorted 44", d, 32'd44);

    // R8 soft reset
    wr(8'h10, 32'h2);
    rd(8'h14, d); check("R8 status busy", d, 32'h0);
    wr(8'h88, 32'hFFFFFFFF);
    cnt = 0;
    rd(8'h14, d);
    while (d[0] == 1'b0 && cnt < 20) begin
      tick(); cnt++;
      rd(8'h14, d);
    end
    check("R8 busy length", 32'(cnt), 32'(RSTCYC - 1));
    rd(8'h88, d); check("R8 mask restored, write ignored", d, 32'hFFFFFFFF);
    rd(8'hA8, d); check("R8 bank1 mask restored", d, 32'hFFFFFFFF);
    rd(8'h68, d); check("R8 thr restored", d, 32'hFF);
    check("R8 irq low", 32'(irqOut), 32'h0);

    // Random rounds: R2 R3 R4 R6 R7
    for (int it = 0; it < 60; it++) begin
      for (int b = 0; b < NBANK; b++) begin
        logic [31:0] m, s, f;
        m = $urandom | $urandom;
        s = $urandom & $urandom & $urandom;
        f = (it % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
        wr(bankAddr(b, 0), 32'hFFFFFFFF);
        wr(bankAddr(b, 1), m);
        wr(bankAddr(b, 3), 32'hFFFFFFFF);
        wr(bankAddr(b, 2), f);
        modelMask[b*32 +: 32] = m;
        modelSw[b*32 +: 32]   = f;
        modelSrc[b*32 +: 32]  = s;
      end
      srcLevel = modelSrc;
      wr(8'h48, 32'h1);
      tick();
      exp = lowestPending((modelSrc | modelSw) & ~modelMask);
      rd(8'h40, d);
      if (exp < 0) begin
        check("R4 rand no irq", 32'(irqOut), 32'h0);
        check("R7 rand spurious", d & 32'hFFFFFF80, 32'hFFFFFF80);
      end else begin
        check("R4 rand irq", 32'(irqOut), 32'h1);
        check("R4 rand lowest", d, 32'(exp));
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule